// File: doc/BRIEF.md
# Helicity Pattern Sequencer

This block produces the real-time helicity state of a polarized beam, one window at a time. Each pulse on the window-advance strobe moves the sequencer to the next window. At the first window of every pattern, a 30-bit maximal-length shift register supplies one pseudo-random bit. That bit decides whether the pattern runs its base sequence or the complement of it. The available patterns are Pair, Quartet, Octet and two long block patterns, Hexo-Quad and Octo-Quad. A Toggle mode alternates the state every window and uses no random bit. Window timing (settle and stable intervals) is produced elsewhere and arrives only as the strobe.

Besides the helicity and its complement, the block drives a pair marker that alternates every window and a pattern marker that is high in the first window of each pattern. It also drives two intensity-attenuator controls, which carry the polarity of the current pattern and of the one before it. The pattern code is sampled only when a pattern begins. In line-synchronous operation the two long patterns are not allowed, and they fall back to Toggle. Software can load a new nonzero seed into the shift register at any time.

Top module: `helicity_seq`

## Requirements
- R1: After reset, `hel_flip`=0, `hel_flip_n`=1, `pair_sync`=0, `pat_sync`=0, `ia_cur`=0 and `ia_prev`=0, and the shift register holds 30'h2468ACE1. The first strobe after reset starts a new pattern.
- R2: When a pattern using a random bit starts, the bit drawn is the XOR of register bits 30, 29, 28 and 7, counting from 1 at the LSB. The register shifts left and the new bit enters at bit 1. Drawn bit 0 gives a pattern whose first window has `hel_flip`=1 ("+"). Drawn bit 1 inverts the whole pattern.
- R3: With "+" first and indices counted from the pattern start, the sequences are: Pair (code 0) is + −. Quartet (code 1) is + − − +. Octet (code 2) is + − − + − + + −.
- R4: Hexo-Quad (code 4) is + − − + repeated three times, then − + + − repeated three times, for 24 windows. Octo-Quad (code 5) is four of each, for 32 windows.
- R5: Codes 3, 6 and 7 select Toggle. Toggle is + − every window and draws no bit, so the shift register is left unchanged.
- R6: When `line_sync_mode`=1, codes 4 and 5 behave as Toggle. Codes 0 to 2 are not affected by this input.
- R7: `pair_sync` is 1 in even windows and 0 in odd windows of a pattern, so it alternates on every strobe. `pat_sync` is 1 only in window 0. For Pair the two outputs are identical.
- R8: `hel_flip_n` is always the inverse of `hel_flip`.
- R9: At each pattern start, `ia_cur` takes the drawn bit (0 for Toggle), and `ia_prev` takes the previous value of `ia_cur`.
- R10: `seed_ld` with a nonzero `seed_in` loads the register. A zero `seed_in` is ignored. If the load falls in the same cycle as a pattern start, the pattern's bit comes from the old register contents and the loaded seed replaces the shifted value.
- R11: A change of `pat_sel` or `line_sync_mode` inside a pattern takes effect only at the next pattern start.
- R12: In a cycle with neither strobe nor load, every output and the shift register hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_adv | input | 1 | Advance to the next helicity window |
| pat_sel | input | 3 | Pattern code |
| line_sync_mode | input | 1 | Line-synchronous operation; forbids long patterns |
| seed_ld | input | 1 | Load `seed_in` into the shift register |
| seed_in | input | 30 | Seed value; zero is ignored |
| hel_flip | output | 1 | Real-time helicity, 1 = "+" |
| hel_flip_n | output | 1 | Complement of `hel_flip` |
| pair_sync | output | 1 | High in the first window of each pair |
| pat_sync | output | 1 | High in the first window of each pattern |
| ia_cur | output | 1 | Polarity of the current pattern |
| ia_prev | output | 1 | Polarity of the previous pattern |

## Verification
The collision that matters is a seed load landing in the same cycle as a pattern-start draw. In that cycle the register both needs to shift and is being overwritten. The bench raises `seed_ld` together with the strobe that opens a pattern. It checks that this pattern's polarity follows the old register contents, and that the next several patterns follow the new seed with no extra shift. A second overlap is a pattern-code change inside a running pattern. The bench checks that the running pattern completes unchanged and that the new code governs the pattern that follows.

// File: rtl/helicity_seq.sv
module helicity_seq #(
  parameter logic [29:0] RESET_SEED = 30'h2468ACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        win_adv,
  input  logic [2:0]  pat_sel,
  input  logic        line_sync_mode,
  input  logic        seed_ld,
  input  logic [29:0] seed_in,
  output logic        hel_flip,
  output logic        hel_flip_n,
  output logic        pair_sync,
  output logic        pat_sync,
  output logic        ia_cur,
  output logic        ia_prev
);

  typedef enum logic [2:0] {K_PAIR, K_QUAD, K_OCT, K_TOG, K_HEX, K_OCTQ} kind_t;

  logic [29:0] lfsr;
  logic [4:0]  idx;
  kind_t       kind;
  logic        pol, run;

  function automatic kind_t decode(input logic [2:0] sel, input logic ls);
    case (sel)
      3'd0:    return K_PAIR;
      3'd1:    return K_QUAD;
      3'd2:    return K_OCT;
      3'd4:    return ls ? K_TOG : K_HEX;
      3'd5:    return ls ? K_TOG : K_OCTQ;
      default: return K_TOG;
    endcase
  endfunction

  function automatic logic [4:0] last_of(input kind_t k);
    case (k)
      K_QUAD:  return 5'd3;
      K_OCT:   return 5'd7;
      K_HEX:   return 5'd23;
      K_OCTQ:  return 5'd31;
      default: return 5'd1;
    endcase
  endfunction

  kind_t next_kind;
  logic  new_bit, starting, next_rand, quad_bit, tmpl, draw;

  assign next_kind = decode(pat_sel, line_sync_mode);
  assign next_rand = (next_kind != K_TOG);
  assign new_bit   = lfsr[29] ^ lfsr[28] ^ lfsr[27] ^ lfsr[6];
  assign starting  = win_adv && (!run || idx == last_of(kind));
  assign draw      = next_rand ? new_bit : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr    <= RESET_SEED;
      idx     <= '0;
      kind    <= K_TOG;
      pol     <= 1'b0;
      run     <= 1'b0;
      ia_cur  <= 1'b0;
      ia_prev <= 1'b0;
    end else begin
      if (starting) begin
        run     <= 1'b1;
        idx     <= '0;
        kind    <= next_kind;
        pol     <= draw;
        ia_cur  <= draw;
        ia_prev <= ia_cur;
      end else if (win_adv) begin
        idx <= idx + 5'd1;
      end
      if (seed_ld && seed_in != '0)
        lfsr <= seed_in;
      else if (starting && next_rand)
        lfsr <= {lfsr[28:0], new_bit};
    end
  end

  assign quad_bit = ~(idx[0] ^ idx[1]);

  always_comb begin
    case (kind)
      K_QUAD:  tmpl = quad_bit;
      K_OCT:   tmpl = quad_bit ^ idx[2];
      K_HEX:   tmpl = quad_bit ^ (idx >= 5'd12);
      K_OCTQ:  tmpl = quad_bit ^ idx[4];
      default: tmpl = ~idx[0];
    endcase
  end

  assign hel_flip   = run & (tmpl ^ pol);
  assign hel_flip_n = ~hel_flip;
  assign pair_sync  = run & ~idx[0];
  assign pat_sync   = run & (idx == 5'd0);

  p_pair_alt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && win_adv) |=> (pair_sync != $past(pair_sync)));

  p_pair_eq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_PAIR) |-> (pat_sync == pair_sync));

  p_ia_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
    starting |=> (ia_prev == $past(ia_cur)));

  p_seed_nz_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);

  p_fallback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (starting && line_sync_mode) |=> (kind != K_HEX && kind != K_OCTQ));

  p_tog_nodraw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (starting && !next_rand && !seed_ld) |=> $stable(lfsr));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_adv && !seed_ld) |=> ($stable(lfsr) && $stable(hel_flip) && $stable(pat_sync) && $stable(ia_cur)));

endmodule

// File: tb/helicity_seq_tb.sv
module helicity_seq_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        win_adv = 0;
  logic [2:0]  pat_sel = 0;
  logic        line_sync_mode = 0;
  logic        seed_ld = 0;
  logic [29:0] seed_in = 0;
  logic        hel_flip, hel_flip_n, pair_sync, pat_sync, ia_cur, ia_prev;

  int n_run = 0, n_fail = 0;
  logic [29:0] m;
  logic e_cur, e_prev;

  always #10 clk = ~clk;

  helicity_seq u_dut (
    .clk(clk), .rst_n(rst_n), .win_adv(win_adv), .pat_sel(pat_sel),
    .line_sync_mode(line_sync_mode), .seed_ld(seed_ld), .seed_in(seed_in),
    .hel_flip(hel_flip), .hel_flip_n(hel_flip_n), .pair_sync(pair_sync),
    .pat_sync(pat_sync), .ia_cur(ia_cur), .ia_prev(ia_prev)
  );

  // fields: {code[2:0], line_sync, patterns[3:0]}
  localparam logic [7:0] VEC [12] = '{
    {3'd0, 1'b0, 4'd3}, {3'd1, 1'b0, 4'd2}, {3'd2, 1'b0, 4'd2}, {3'd3, 1'b0, 4'd3},
    {3'd4, 1'b0, 4'd1}, {3'd5, 1'b0, 4'd1}, {3'd4, 1'b1, 4'd2}, {3'd5, 1'b1, 4'd1},
    {3'd6, 1'b0, 4'd2}, {3'd7, 1'b1, 4'd1}, {3'd2, 1'b1, 4'd1}, {3'd0, 1'b1, 4'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic adv();
    win_adv = 1;
    @(negedge clk);
    win_adv = 0;
  endtask

  function automatic logic draw_bit(input logic [29:0] r);
    return r[29] ^ r[28] ^ r[27] ^ r[6];
  endfunction

  task automatic spec(input logic [2:0] c, input logic ls, output int len,
                      output logic [31:0] t, output bit rnd, output string tag);
    rnd = 1; tag = "R3";
    case (c)
      3'd0: begin len = 2; t = 32'h1; end
      3'd1: begin len = 4; t = 32'h9; end
      3'd2: begin len = 8; t = 32'h69; end
      3'd4: begin len = 24; t = 32'h666999; tag = "R4"; end
      3'd5: begin len = 32; t = 32'h66669999; tag = "R4"; end
      default: begin len = 2; t = 32'h1; rnd = 0; tag = "R5"; end
    endcase
    if (ls && (c == 3'd4 || c == 3'd5)) begin
      len = 2; t = 32'h1; rnd = 0; tag = "R6";
    end
  endtask

  task automatic check_win(input string tag, input int w, input logic eh);
    logic en;
    en = ~eh;
    chk(tag, hel_flip, eh);
    chk("R8", hel_flip_n, en);
    chk("R7 pair", pair_sync, (w % 2) == 0);
    chk("R7 pat", pat_sync, w == 0);
    chk("R9 cur", ia_cur, e_cur);
    chk("R9 prev", ia_prev, e_prev);
  endtask

  task automatic run_pat(input logic [2:0] code, input logic ls, input bit mid,
                         input logic [2:0] mid_code);
    int len; logic [31:0] t; bit rnd; string tag; logic pol;
    spec(code, ls, len, t, rnd, tag);
    pat_sel = code; line_sync_mode = ls;
    if (rnd) begin pol = draw_bit(m); m = {m[28:0], pol}; end
    else pol = 0;
    e_prev = e_cur; e_cur = pol;
    for (int w = 0; w < len; w++) begin
      adv();
      check_win((w == 0 && rnd) ? "R2" : tag, w, t[w] ^ pol);
      if (mid && w == 0) begin pat_sel = mid_code; line_sync_mode = 0; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    m = 30'h2468ACE1; e_cur = 0; e_prev = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 hel", hel_flip, 0);
    chk("R1 heln", hel_flip_n, 1);
    chk("R1 pair", pair_sync, 0);
    chk("R1 pat", pat_sync, 0);
    chk("R1 ia", {ia_cur, ia_prev}, 0);

    foreach (VEC[i]) begin
      for (int p = 0; p < int'(VEC[i][3:0]); p++)
        run_pat(VEC[i][7:5], VEC[i][4], 0, 3'd0);
    end

    // R10: zero seed ignored
    seed_in = 0; seed_ld = 1; @(negedge clk); seed_ld = 0;
    for (int k = 0; k < 4; k++) run_pat(3'd1, 0, 0, 3'd0);

    // R10: nonzero load while idle
    seed_in = 30'h15F00F3C; seed_ld = 1; @(negedge clk); seed_ld = 0;
    m = 30'h15F00F3C;
    for (int k = 0; k < 6; k++) run_pat(3'd0, 0, 0, 3'd0);

    // R10: load coincides with a pattern-start draw
    begin
      logic pol;
      pat_sel = 3'd0; line_sync_mode = 0;
      pol = draw_bit(m);
      m = 30'h0ABCDEF1;
      e_prev = e_cur; e_cur = pol;
      seed_in = 30'h0ABCDEF1; seed_ld = 1;
      adv();
      seed_ld = 0;
      check_win("R10 collide", 0, 1'b1 ^ pol);
      adv();
      check_win("R10 collide", 1, 1'b0 ^ pol);
    end
    for (int k = 0; k < 6; k++) run_pat(3'd0, 0, 0, 3'd0);

    // R11: code change mid-pattern applies at next pattern
    run_pat(3'd1, 0, 1, 3'd5);
    run_pat(3'd5, 0, 0, 3'd0);
    run_pat(3'd2, 0, 1, 3'd0);
    run_pat(3'd0, 0, 0, 3'd0);

    // R12: no strobe, no load -> hold
    run_pat(3'd1, 0, 0, 3'd0);
    begin
      logic h0, p0, c0, q0;
      h0 = hel_flip; p0 = pair_sync; c0 = ia_cur; q0 = pat_sync;
      repeat (5) @(negedge clk);
      chk("R12 hel", hel_flip, h0);
      chk("R12 pair", pair_sync, p0);
      chk("R12 pat", pat_sync, q0);
      chk("R12 ia", ia_cur, c0);
    end
    for (int k = 0; k < 3; k++) run_pat(3'd2, 0, 0, 3'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule